// File: doc/BRIEF.md
# External Bus Strobe Generator

This block times the two strobes of an 8051-style external memory bus from the oscillator clock. These are the address latch enable (ALE, active high) and the program store enable (PSEN, active low). A machine cycle lasts twelve oscillator clocks, arranged as six states of two clocks each. Phases are numbered 0 to 11. Phase 0 is the clock period that follows the first rising edge of a machine cycle. ALE normally pulses twice per machine cycle, which is one sixth of the oscillator rate. PSEN pulses twice per machine cycle when code is fetched from outside the chip.

On the first edge of each machine cycle the block samples four qualifiers. These are an ALE-disable control bit, an external-execution flag, a flag marking the cycle as an external data move, and a flag marking it as a code-table read. The sampled values govern the whole cycle. A data-move cycle drops the second ALE pulse and both PSEN pulses, which leaves bus time for the data transfer. When the disable bit is set during internal execution, ALE stays parked high in ordinary cycles. It pulses only in data-move and code-table cycles. External execution overrides the disable bit.

The address/data multiplexing and the instruction decode sit outside this block. Those blocks supply the qualifiers one clock ahead of each machine cycle.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `ale` = 0 and `psen_n` = 1. After `rst` falls, the next rising edge starts a new machine cycle at phase 0.
- R2: A machine cycle is 12 clocks long. The qualifier inputs are sampled only on the rising edge that begins phase 0. Changes to them during the cycle have no effect until the next cycle.
- R3: In an enabled cycle that is not a data move, `ale` is 1 in phases 1, 2, 7 and 8 and 0 in the other phases. The enable condition is that the disable bit is clear, or external execution is set, or the cycle is a code-table read.
- R4: In a data-move cycle (`xdata_cyc` = 1), `ale` is 1 only in phases 1 and 2. The pulse in phases 7 and 8 is omitted.
- R5: With `ext_exec` = 1 in a cycle that is not a data move, `psen_n` is 0 in phases 3, 4, 5, 9, 10 and 11 and 1 in the other phases.
- R6: In a data-move cycle, `psen_n` stays 1 in all 12 phases, even with `ext_exec` = 1.
- R7: With `ext_exec` = 0, `psen_n` stays 1 in all 12 phases.
- R8: With `ale_off` = 1 and `ext_exec` = 0, a cycle that is neither a data move nor a code-table read keeps `ale` at 1 in all 12 phases. This is the default `ALE_PARK_HIGH` = 1.
- R9: With `ext_exec` = 1, `ale_off` has no effect on `ale`.
- R10: With `ale_off` = 1 and `ext_exec` = 0, a code-table cycle pulses `ale` as in R3, and a data-move cycle pulses it as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_off | input | 1 | ALE-disable control bit |
| ext_exec | input | 1 | Code is being executed from external program memory |
| xdata_cyc | input | 1 | Next machine cycle is an external data move |
| ctab_cyc | input | 1 | Next machine cycle is a code-table read |
| ale | output | 1 | Address latch enable, active high, registered |
| psen_n | output | 1 | Program store enable, active low, registered |

## Verification
Several properties are checked on every cycle. The phase counter wraps after twelve clocks, and the sampled qualifiers hold steady inside a machine cycle. The two strobes are never active together. PSEN is active only when the held flags say external execution without a data move. Each ALE pulse lasts at least two clocks and each PSEN pulse at least two, and reset idles both strobes. The exact phase positions of the pulses are shown only by the bench's scenarios. So are the skip and park patterns for each combination of qualifiers, the blindness to mid-cycle qualifier changes, and the realignment after a reset in the middle of a cycle.

// File: rtl/strb_pkg.sv
package strb_pkg;

   // Qualifiers held for one machine cycle
   typedef struct packed {
      logic aoff;   // ALE-disable bit
      logic ext;    // executing from external code
      logic xd;     // external data move cycle
      logic ct;     // code-table read cycle
   } cyc_flags_t;

   localparam cyc_flags_t FLAGS_IDLE = '{aoff: 1'b0, ext: 1'b0, xd: 1'b0, ct: 1'b0};

endpackage

// File: rtl/strb_phase_ctr.sv
module strb_phase_ctr
   import strb_pkg::*;
#(
   parameter int CYC_LEN = 12,
   localparam int PH_W   = $clog2(CYC_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  cyc_flags_t       flags_in,
   output logic [PH_W-1:0]  phase_nxt,
   output cyc_flags_t       flags_nxt,
   output logic [PH_W-1:0]  phase_q,
   output cyc_flags_t       flags_q
);

   localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

   generate
      if (CYC_LEN < 4) begin : g_bad_len
         $error("strb_phase_ctr: CYC_LEN must be at least 4");
      end
   endgenerate

   logic wrap;

   always_comb begin
      wrap      = (phase_q == LAST);
      phase_nxt = wrap ? '0 : phase_q + 1'b1;
      flags_nxt = wrap ? flags_in : flags_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= LAST;
         flags_q <= FLAGS_IDLE;
      end else begin
         phase_q <= phase_nxt;
         flags_q <= flags_nxt;
      end
   end

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (phase_q == LAST) |=> (phase_q == '0)) else $error("phase wrap"); // R2

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
      (phase_q <= LAST)) else $error("phase range"); // R2

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
      (phase_q != LAST) |=> $stable(flags_q)) else $error("flags moved mid-cycle"); // R2

endmodule

// File: rtl/strb_decode.sv
module strb_decode
   import strb_pkg::*;
#(
   parameter int CYC_LEN       = 12,
   parameter int ALE_BEGIN     = 1,
   parameter int ALE_LEN       = 2,
   parameter int PSEN_BEGIN    = 3,
   parameter int PSEN_LEN      = 3,
   parameter bit ALE_PARK_HIGH = 1'b1,
   localparam int PH_W         = $clog2(CYC_LEN),
   localparam int HALF         = CYC_LEN / 2
) (
   input  logic [PH_W-1:0] phase,
   input  cyc_flags_t      flags,
   output logic            ale_d,
   output logic            psen_low_d
);

   generate
      if ((CYC_LEN % 2) != 0) begin : g_bad_half
         $error("strb_decode: CYC_LEN must be even");
      end
      if (ALE_BEGIN < 1 || ALE_LEN < 2 || ALE_BEGIN + ALE_LEN > HALF) begin : g_bad_ale
         $error("strb_decode: ALE window must fit in a half cycle");
      end
      if (PSEN_LEN < 2 || PSEN_BEGIN + PSEN_LEN > HALF) begin : g_bad_psen
         $error("strb_decode: PSEN window must fit in a half cycle");
      end
      if (PSEN_BEGIN < ALE_BEGIN + ALE_LEN) begin : g_bad_order
         $error("strb_decode: PSEN window must follow the ALE window");
      end
   endgenerate

   logic ale_idle;

   generate
      if (ALE_PARK_HIGH) begin : g_park_high
         assign ale_idle = 1'b1;
      end else begin : g_park_low
         assign ale_idle = 1'b0;
      end
   endgenerate

   logic ale_w1, ale_w2, psen_w;
   logic ale_en;
   int   ph;

   always_comb begin
      ph     = int'(phase);
      ale_w1 = (ph >= ALE_BEGIN) && (ph < ALE_BEGIN + ALE_LEN);
      ale_w2 = (ph >= ALE_BEGIN + HALF) && (ph < ALE_BEGIN + HALF + ALE_LEN);
      psen_w = ((ph >= PSEN_BEGIN) && (ph < PSEN_BEGIN + PSEN_LEN)) ||
               ((ph >= PSEN_BEGIN + HALF) && (ph < PSEN_BEGIN + HALF + PSEN_LEN));
      ale_en = flags.ext | ~flags.aoff | flags.xd | flags.ct;
      ale_d  = ale_en ? (ale_w1 | (ale_w2 & ~flags.xd)) : ale_idle;
      psen_low_d = flags.ext & ~flags.xd & psen_w;
   end

endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
   import strb_pkg::*;
#(
   parameter int STATE_CLKS    = 2,
   parameter int CYC_STATES    = 6,
   parameter int ALE_BEGIN     = 1,
   parameter int ALE_LEN       = 2,
   parameter int PSEN_BEGIN    = 3,
   parameter int PSEN_LEN      = 3,
   parameter bit ALE_PARK_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ale_off,
   input  logic ext_exec,
   input  logic xdata_cyc,
   input  logic ctab_cyc,
   output logic ale,
   output logic psen_n
);

   localparam int CYC_LEN = STATE_CLKS * CYC_STATES;
   localparam int PH_W    = $clog2(CYC_LEN);

   generate
      if (STATE_CLKS < 1 || CYC_STATES < 2) begin : g_bad_cfg
         $error("ext_bus_strobe_gen: bad machine cycle shape");
      end
   endgenerate

   cyc_flags_t      flags_in, flags_nxt, flags_q;
   logic [PH_W-1:0] phase_nxt, phase_q;
   logic            ale_d, psen_low_d;

   assign flags_in = '{aoff: ale_off, ext: ext_exec, xd: xdata_cyc, ct: ctab_cyc};

   strb_phase_ctr #(.CYC_LEN(CYC_LEN)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .flags_in  (flags_in),
      .phase_nxt (phase_nxt),
      .flags_nxt (flags_nxt),
      .phase_q   (phase_q),
      .flags_q   (flags_q)
   );

   strb_decode #(
      .CYC_LEN       (CYC_LEN),
      .ALE_BEGIN     (ALE_BEGIN),
      .ALE_LEN       (ALE_LEN),
      .PSEN_BEGIN    (PSEN_BEGIN),
      .PSEN_LEN      (PSEN_LEN),
      .ALE_PARK_HIGH (ALE_PARK_HIGH)
   ) u_dec (
      .phase      (phase_nxt),
      .flags      (flags_nxt),
      .ale_d      (ale_d),
      .psen_low_d (psen_low_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ale    <= 1'b0;
         psen_n <= 1'b1;
      end else begin
         ale    <= ale_d;
         psen_n <= ~psen_low_d;
      end
   end

   AST_RST_IDLE: assert property (@(posedge clk)
      rst |=> (!ale && psen_n)) else $error("reset idle"); // R1

   AST_STRB_EXCL: assert property (@(posedge clk) disable iff (rst)
      !psen_n |-> !ale) else $error("strobes overlap"); // R5

   AST_PSEN_QUAL: assert property (@(posedge clk) disable iff (rst)
      !psen_n |-> (flags_q.ext && !flags_q.xd)) else $error("PSEN unqualified"); // R6

   AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $rose(ale) |=> ale) else $error("ALE too short"); // R3

   AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(psen_n) |=> !psen_n) else $error("PSEN too short"); // R5

endmodule

// File: tb/ext_bus_strobe_gen_test.sv
module ext_bus_strobe_gen_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ale_off = 1'b0, ext_exec = 1'b0, xdata_cyc = 1'b0, ctab_cyc = 1'b0;
   logic ale, psen_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ext_bus_strobe_gen uut (
      .clk(clk), .rst(rst), .ale_off(ale_off), .ext_exec(ext_exec),
      .xdata_cyc(xdata_cyc), .ctab_cyc(ctab_cyc), .ale(ale), .psen_n(psen_n)
   );

   // {aoff, ext, xd, ct, ALE per phase [11:0], PSEN-low per phase [11:0]}
   // ALE phases 1,2 = 12'h006; phases 7,8 = 12'h180; PSEN low 3-5,9-11 = 12'hE38
   localparam logic [27:0] VEC [12] = '{
      28'h0186000, 28'h4186E38, 28'h6006000, 28'h2006000,
      28'h8FFF000, 28'hC186E38, 28'h9186000, 28'hA006000,
      28'h5186E38, 28'hE006000, 28'h1186000, 28'h8FFF000
   };

   task automatic check(input bit ok, input string tag, input logic [11:0] act,
                        input logic [11:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_in(input logic [3:0] f);
      {ale_off, ext_exec, xdata_cyc, ctab_cyc} = f;
   endtask

   // Runs one machine cycle; inputs must already be set. Optionally changes
   // the qualifiers after phase 4 to test mid-cycle insensitivity.
   task automatic run_cycle(input bit poke, input logic [3:0] poke_val,
                            output logic [11:0] a, output logic [11:0] p);
      for (int ph = 0; ph < 12; ph++) begin
         @(posedge clk);
         @(negedge clk);
         a[ph] = ale;
         p[ph] = ~psen_n;
         if (poke && ph == 4) set_in(poke_val);
      end
   endtask

   function automatic string ale_tag(input logic [3:0] f);
      if (f[1]) return "R4";
      if (f[3] && !f[2] && !f[0]) return "R8";
      if (f[3] && f[2]) return "R9";
      if (f[3]) return "R10";
      return "R3";
   endfunction

   function automatic string psen_tag(input logic [3:0] f);
      if (!f[2]) return "R7";
      if (f[1]) return "R6";
      return "R5";
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [11:0] a, p;
      // R1: idle outputs under reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(ale == 1'b0, "R1 ale in reset", {11'b0, ale}, 12'h000);
      check(psen_n == 1'b1, "R1 psen_n in reset", {11'b0, psen_n}, 12'h001);
      rst = 1'b0;

      // Table walk: R3..R10 phase patterns per qualifier combination
      for (int v = 0; v < 12; v++) begin
         set_in(VEC[v][27:24]);
         run_cycle(1'b0, 4'h0, a, p);
         check(a == VEC[v][23:12], ale_tag(VEC[v][27:24]), a, VEC[v][23:12]);
         check(p == VEC[v][11:0], psen_tag(VEC[v][27:24]), p, VEC[v][11:0]);
      end

      // R2: qualifiers changed mid-cycle have no effect on this cycle
      set_in(4'b0100);
      run_cycle(1'b1, 4'b1110, a, p);
      check(a == 12'h186, "R2 ale mid-cycle change", a, 12'h186);
      check(p == 12'hE38, "R2 psen mid-cycle change", p, 12'hE38);
      // R2: the changed values take effect in the next cycle
      run_cycle(1'b0, 4'h0, a, p);
      check(a == 12'h006, "R2 ale next cycle", a, 12'h006);
      check(p == 12'h000, "R2 psen next cycle", p, 12'h000);

      // R1: reset in the middle of a cycle, then realignment to phase 0
      set_in(4'b0100);
      for (int k = 0; k < 5; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(ale == 1'b0 && psen_n == 1'b1, "R1 mid-cycle reset",
            {10'b0, ale, psen_n}, 12'h001);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      run_cycle(1'b0, 4'h0, a, p);
      check(a == 12'h186, "R1 ale after reset release", a, 12'h186);
      check(p == 12'hE38, "R1 psen after reset release", p, 12'hE38);

      done = 1'b1;
      finish_run();
   end

endmodule